// File: doc/BRIEF.md
# Two-Step PTP Transmit Timestamp Writeback Engine

This block sits beside the transmit side of an Ethernet MAC. At the start of each outgoing frame, the DMA sideband supplies a 2-bit PTP flag and a destination address for that frame. The block turns the flag into the 2-bit timestamp-operation code that the MAC expects. For a two-step frame, it also keeps the destination address in an in-order queue that holds up to four pending requests.

When the MAC and timer logic return an 80-bit egress timestamp, the block takes the oldest queued address. It then writes the timestamp there as a single two-beat incrementing AXI4 burst of 64-bit beats. When the write response arrives, it raises a sticky completion bit, or a separate error bit if the response is not OKAY. Software clears both bits with a one-cycle clear pulse.

The block has one write state machine. Its states are `WB_IDLE`, `WB_ADDR`, `WB_DATA_LO`, `WB_DATA_HI` and `WB_RESP`.
- `WB_IDLE` moves to `WB_ADDR` when a timestamp is accepted (start).
- `WB_ADDR` moves to `WB_DATA_LO` on the address handshake (aw_done).
- `WB_DATA_LO` moves to `WB_DATA_HI` on the first data handshake (lo_done).
- `WB_DATA_HI` moves to `WB_RESP` on the last data handshake (hi_done).
- `WB_RESP` moves back to `WB_IDLE` on the response handshake (b_done).
- Each state stays where it is while its own handshake is missing.

Top module: `tstamp_wb_master`

## Requirements
- R1: After reset, `mac_op_valid`, `axi_awvalid`, `axi_wvalid`, `axi_bready`, `done_flag`, `err_flag` and `ts_ready` are 0, `mac_op` is 00, and `sof_ready` is 1.
- R2: A frame is accepted on a clock edge where both `sof_valid` and `sof_ready` are high. In the following cycle, `mac_op_valid` is 1 for exactly one cycle. In that cycle, `mac_op` is 10 (two-step) if `sof_flag` was 10, and 00 (no operation) for flags 00, 01 and 11. The value 11 never appears on `mac_op`.
- R3: Only a frame with flag 10 queues a timestamp write. Frames with flags 00, 01 or the reserved 11 leave `ts_ready` low and start no AXI transaction.
- R4: Each write issues one address phase. Its `axi_awaddr` is the address given with the matching frame, `axi_awlen` is 1, `axi_awsize` is 3 (8 bytes) and `axi_awburst` is 01 (INCR). `axi_awvalid` and `axi_awaddr` hold until `axi_awready`, and the data phase starts only after the address handshake.
- R5: The first data beat carries timestamp[63:0] with `axi_wlast` at 0. The second beat carries timestamp[79:64] zero-extended to 64 bits with `axi_wlast` at 1. `axi_wstrb` is all ones, and `axi_wvalid` holds each beat until `axi_wready`.
- R6: After the two beats, `axi_bready` is 1. On the response handshake, `done_flag` becomes 1 from the next cycle if `axi_bresp` is 00 (OKAY). Otherwise `err_flag` becomes 1 and `done_flag` stays unchanged.
- R7: A one-cycle `clr_status` pulse clears both `done_flag` and `err_flag`. If a set and a clear land in the same cycle, the set wins.
- R8: Up to 4 two-step requests can be pending. `sof_ready` is 0 while 4 are pending, and a `sof_valid` in that state is ignored (no `mac_op_valid`). Timestamps are matched to addresses in the order the frames were accepted.
- R9: `ts_ready` is 1 only while the writer is idle and at least one request is pending. A `ts_valid` while `ts_ready` is 0 is ignored and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_valid | input | 1 | Start of frame with sideband fields |
| sof_ready | output | 1 | Request queue can take a frame |
| sof_flag | input | 2 | Software PTP flag for the frame |
| sof_addr | input | 32 | Timestamp destination address |
| mac_op_valid | output | 1 | Operation code strobe to the MAC |
| mac_op | output | 2 | Timestamp operation code to the MAC |
| ts_valid | input | 1 | Returned timestamp is present |
| ts_ready | output | 1 | Timestamp can be accepted |
| ts_value | input | 80 | Returned egress timestamp |
| axi_awaddr | output | 32 | Write address |
| axi_awlen | output | 8 | Burst length minus one |
| axi_awsize | output | 3 | Beat size code |
| axi_awburst | output | 2 | Burst type |
| axi_awvalid | output | 1 | Address valid |
| axi_awready | input | 1 | Address ready |
| axi_wdata | output | 64 | Write data |
| axi_wstrb | output | 8 | Byte strobes |
| axi_wlast | output | 1 | Last beat |
| axi_wvalid | output | 1 | Data valid |
| axi_wready | input | 1 | Data ready |
| axi_bresp | input | 2 | Write response code |
| axi_bvalid | input | 1 | Response valid |
| axi_bready | output | 1 | Response ready |
| clr_status | input | 1 | Write-one-to-clear pulse for both status bits |
| done_flag | output | 1 | Sticky write-completed bit |
| err_flag | output | 1 | Sticky write-error bit |

## Verification
The hardest case to reach is a full queue with four addresses pending and no timestamp returned. The stimulus accepts four two-step frames back to back while holding `ts_valid` low. It then offers a fifth frame that must be refused, and finally returns four timestamps whose order must match the addresses.

A second hard case is a status set that coincides with a clear. The bench's response model raises `clr_status` in the same cycle as `axi_bvalid`, which forces the set-wins rule. Reserved and unused flags are mixed into a table of frames between two-step frames, so that a stray write or a stray `ts_ready` would show up.

// File: rtl/tswb_pkg.sv
package tswb_pkg;

    localparam logic [1:0] PTP_FLAG_TWO_STEP = 2'b10;
    localparam logic [1:0] MAC_OP_NONE       = 2'b00;
    localparam logic [1:0] MAC_OP_TWO_STEP   = 2'b10;
    localparam logic [1:0] AXI_BURST_INCR    = 2'b01;
    localparam logic [1:0] AXI_RESP_OKAY     = 2'b00;

    typedef enum logic [2:0] {
        WB_IDLE    = 3'd0,
        WB_ADDR    = 3'd1,
        WB_DATA_LO = 3'd2,
        WB_DATA_HI = 3'd3,
        WB_RESP    = 3'd4
    } wb_state_t;

endpackage

// File: rtl/tswb_op_encode.sv
module tswb_op_encode
    import tswb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic [1:0] flag,
    output logic       op_valid,
    output logic [1:0] op_code
);

    logic [1:0] code_next;

    always_comb begin
        unique case (flag)
            PTP_FLAG_TWO_STEP: code_next = MAC_OP_TWO_STEP;
            default:           code_next = MAC_OP_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_code  <= MAC_OP_NONE;
        end else begin
            op_valid <= accept;
            op_code  <= accept ? code_next : MAC_OP_NONE;
        end
    end

    // R2: a strobe only ever follows an accepted frame
    assert_op_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(accept));

    // R2: reserved code never reaches the MAC
    assert_op_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_code == MAC_OP_NONE || op_code == MAC_OP_TWO_STEP));

endmodule

// File: rtl/tswb_addr_fifo.sv
module tswb_addr_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_C  = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    count;

    assign full  = (count == DEPTH_C);
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push || pop);

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

endmodule

// File: rtl/tswb_axi_writer.sv
module tswb_axi_writer
    import tswb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TS_W   = 80,
    parameter int BEAT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [TS_W-1:0]   start_ts,
    output logic              idle,
    output logic [ADDR_W-1:0] awaddr,
    output logic [7:0]        awlen,
    output logic [2:0]        awsize,
    output logic [1:0]        awburst,
    output logic              awvalid,
    input  logic              awready,
    output logic [BEAT_W-1:0] wdata,
    output logic [BEAT_W/8-1:0] wstrb,
    output logic              wlast,
    output logic              wvalid,
    input  logic              wready,
    input  logic [1:0]        bresp,
    input  logic              bvalid,
    output logic              bready,
    output logic              resp_ok,
    output logic              resp_bad
);

    localparam int HI_W = TS_W - BEAT_W;
    localparam int PAD_W = BEAT_W - HI_W;
    localparam logic [2:0] SIZE_C = 3'($clog2(BEAT_W / 8));

    wb_state_t state, state_next;
    logic [ADDR_W-1:0] addr_q;
    logic [TS_W-1:0]   ts_q;

    logic aw_done, lo_done, hi_done, b_done;
    assign aw_done = awvalid && awready;
    assign lo_done = (state == WB_DATA_LO) && wready;
    assign hi_done = (state == WB_DATA_HI) && wready;
    assign b_done  = bready && bvalid;

    always_comb begin
        state_next = state;
        unique case (state)
            WB_IDLE:    if (start)   state_next = WB_ADDR;
            WB_ADDR:    if (aw_done) state_next = WB_DATA_LO;
            WB_DATA_LO: if (lo_done) state_next = WB_DATA_HI;
            WB_DATA_HI: if (hi_done) state_next = WB_RESP;
            WB_RESP:    if (b_done)  state_next = WB_IDLE;
            default:                 state_next = WB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WB_IDLE;
        end else begin
            state <= state_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            ts_q   <= '0;
        end else if (state == WB_IDLE && start) begin
            addr_q <= start_addr;
            ts_q   <= start_ts;
        end
    end

    always_comb begin
        idle     = (state == WB_IDLE);
        awaddr   = addr_q;
        awlen    = 8'd1;
        awsize   = SIZE_C;
        awburst  = AXI_BURST_INCR;
        awvalid  = 1'b0;
        wdata    = '0;
        wstrb    = '1;
        wlast    = 1'b0;
        wvalid   = 1'b0;
        bready   = 1'b0;
        resp_ok  = 1'b0;
        resp_bad = 1'b0;
        unique case (state)
            WB_IDLE: ;
            WB_ADDR: awvalid = 1'b1;
            WB_DATA_LO: begin
                wvalid = 1'b1;
                wdata  = ts_q[BEAT_W-1:0];
            end
            WB_DATA_HI: begin
                wvalid = 1'b1;
                wlast  = 1'b1;
                wdata  = {{PAD_W{1'b0}}, ts_q[TS_W-1:BEAT_W]};
            end
            WB_RESP: begin
                bready   = 1'b1;
                resp_ok  = bvalid && (bresp == AXI_RESP_OKAY);
                resp_bad = bvalid && (bresp != AXI_RESP_OKAY);
            end
            default: ;
        endcase
    end

    assert_aw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid && $stable(awaddr));

    assert_w_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

    assert_last_follows_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && wready && !wlast |=> wvalid && wlast);

    assert_channels_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({awvalid, wvalid, bready}));

endmodule

// File: rtl/tstamp_wb_master.sv
module tstamp_wb_master
    import tswb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TS_W   = 80,
    parameter int BEAT_W = 64,
    parameter int QDEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof_valid,
    output logic                sof_ready,
    input  logic [1:0]          sof_flag,
    input  logic [ADDR_W-1:0]   sof_addr,
    output logic                mac_op_valid,
    output logic [1:0]          mac_op,
    input  logic                ts_valid,
    output logic                ts_ready,
    input  logic [TS_W-1:0]     ts_value,
    output logic [ADDR_W-1:0]   axi_awaddr,
    output logic [7:0]          axi_awlen,
    output logic [2:0]          axi_awsize,
    output logic [1:0]          axi_awburst,
    output logic                axi_awvalid,
    input  logic                axi_awready,
    output logic [BEAT_W-1:0]   axi_wdata,
    output logic [BEAT_W/8-1:0] axi_wstrb,
    output logic                axi_wlast,
    output logic                axi_wvalid,
    input  logic                axi_wready,
    input  logic [1:0]          axi_bresp,
    input  logic                axi_bvalid,
    output logic                axi_bready,
    input  logic                clr_status,
    output logic                done_flag,
    output logic                err_flag
);

    logic q_full, q_empty, q_push, q_pop;
    logic [ADDR_W-1:0] q_head;
    logic frame_accept, wr_idle, wr_start, set_done, set_err;

    assign sof_ready    = !q_full;
    assign frame_accept = sof_valid && sof_ready;
    assign q_push       = frame_accept && (sof_flag == PTP_FLAG_TWO_STEP);
    assign ts_ready     = wr_idle && !q_empty;
    assign wr_start     = ts_valid && ts_ready;
    assign q_pop        = wr_start;

    tswb_op_encode u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (frame_accept),
        .flag     (sof_flag),
        .op_valid (mac_op_valid),
        .op_code  (mac_op)
    );

    tswb_addr_fifo #(.WIDTH(ADDR_W), .DEPTH(QDEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (sof_addr),
        .pop       (q_pop),
        .head      (q_head),
        .full      (q_full),
        .empty     (q_empty)
    );

    tswb_axi_writer #(.ADDR_W(ADDR_W), .TS_W(TS_W), .BEAT_W(BEAT_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wr_start),
        .start_addr (q_head),
        .start_ts   (ts_value),
        .idle       (wr_idle),
        .awaddr     (axi_awaddr),
        .awlen      (axi_awlen),
        .awsize     (axi_awsize),
        .awburst    (axi_awburst),
        .awvalid    (axi_awvalid),
        .awready    (axi_awready),
        .wdata      (axi_wdata),
        .wstrb      (axi_wstrb),
        .wlast      (axi_wlast),
        .wvalid     (axi_wvalid),
        .wready     (axi_wready),
        .bresp      (axi_bresp),
        .bvalid     (axi_bvalid),
        .bready     (axi_bready),
        .resp_ok    (set_done),
        .resp_bad   (set_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (set_done)        done_flag <= 1'b1;
            else if (clr_status) done_flag <= 1'b0;
            if (set_err)         err_flag  <= 1'b1;
            else if (clr_status) err_flag  <= 1'b0;
        end
    end

    assert_done_needs_okay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(axi_bvalid && axi_bready && axi_bresp == AXI_RESP_OKAY));

    assert_err_needs_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(axi_bvalid && axi_bready && axi_bresp != AXI_RESP_OKAY));

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_status && !(axi_bvalid && axi_bready) |=> !done_flag && !err_flag);

    assert_ts_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ts_ready |-> !axi_awvalid && !axi_wvalid && !axi_bready);

endmodule

// File: tb/tstamp_wb_master_tb.sv
module tstamp_wb_master_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        sof_valid = 0, sof_ready;
    logic [1:0]  sof_flag = 0;
    logic [31:0] sof_addr = 0;
    logic        mac_op_valid;
    logic [1:0]  mac_op;
    logic        ts_valid = 0, ts_ready;
    logic [79:0] ts_value = 0;
    logic [31:0] axi_awaddr;
    logic [7:0]  axi_awlen;
    logic [2:0]  axi_awsize;
    logic [1:0]  axi_awburst;
    logic        axi_awvalid, axi_awready = 0;
    logic [63:0] axi_wdata;
    logic [7:0]  axi_wstrb;
    logic        axi_wlast, axi_wvalid, axi_wready = 0;
    logic [1:0]  axi_bresp = 0;
    logic        axi_bvalid = 0, axi_bready;
    logic        clr_status = 0, done_flag, err_flag;

    tstamp_wb_master dut_i (.*);

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    task automatic send_sof(input logic [1:0] flag, input logic [31:0] addr);
        sof_valid = 1; sof_flag = flag; sof_addr = addr;
        @(negedge clk);
        sof_valid = 0;
    endtask

    task automatic send_ts(input logic [79:0] ts);
        ts_valid = 1; ts_value = ts;
        @(negedge clk);
        ts_valid = 0;
    endtask

    task automatic slave(input logic [31:0] exp_addr, input logic [79:0] ts,
                         input logic [1:0] resp, input bit clr_with_b);
        while (!axi_awvalid) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R4 awvalid held", 128'(axi_awvalid), 128'(1));
        chk("R4 awaddr", 128'(axi_awaddr), 128'(exp_addr));
        chk("R4 awlen/size/burst", 128'({axi_awlen, axi_awsize, axi_awburst}),
            128'({8'd1, 3'd3, 2'b01}));
        chk("R4 no data before address", 128'(axi_wvalid), 128'(0));
        axi_awready = 1;
        @(negedge clk);
        axi_awready = 0;
        chk("R5 first beat valid", 128'(axi_wvalid), 128'(1));
        chk("R5 first beat", 128'({axi_wdata, axi_wstrb, axi_wlast}),
            128'({ts[63:0], 8'hFF, 1'b0}));
        axi_wready = 1;
        @(negedge clk);
        chk("R5 second beat", 128'({axi_wvalid, axi_wdata, axi_wstrb, axi_wlast}),
            128'({1'b1, 48'h0, ts[79:64], 8'hFF, 1'b1}));
        @(negedge clk);
        axi_wready = 0;
        chk("R6 bready", 128'(axi_bready), 128'(1));
        axi_bvalid = 1; axi_bresp = resp;
        if (clr_with_b) clr_status = 1;
        @(negedge clk);
        axi_bvalid = 0; axi_bresp = 0; clr_status = 0;
    endtask

    task automatic pulse_clear();
        clr_status = 1;
        @(negedge clk);
        clr_status = 0;
        chk("R7 cleared", 128'({done_flag, err_flag}), 128'(0));
    endtask

    // {flag, addr, timestamp, bresp}
    localparam logic [115:0] VEC [6] = '{
        {2'b10, 32'h1000_0040, 80'h1234_0123456789ABCDEF, 2'b00},
        {2'b00, 32'h2000_0000, 80'h0, 2'b00},
        {2'b11, 32'h2000_0010, 80'h0, 2'b00},
        {2'b10, 32'h1000_0080, 80'hFFFF_FFFFFFFFFFFFFFFF, 2'b10},
        {2'b01, 32'h2000_0020, 80'h0, 2'b00},
        {2'b10, 32'hFFFF_FFF8, 80'h8000_0000000000000001, 2'b00}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset outputs",
            128'({mac_op_valid, mac_op, axi_awvalid, axi_wvalid, axi_bready,
                  done_flag, err_flag, ts_ready, sof_ready}),
            128'({1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}));

        for (int i = 0; i < 6; i++) begin
            logic [1:0]  f;
            logic [31:0] a;
            logic [79:0] t;
            logic [1:0]  r;
            {f, a, t, r} = VEC[i];
            send_sof(f, a);
            chk("R2 op strobe", 128'({mac_op_valid, mac_op}),
                128'({1'b1, (f == 2'b10) ? 2'b10 : 2'b00}));
            @(negedge clk);
            chk("R2 single-cycle strobe", 128'(mac_op_valid), 128'(0));
            if (f == 2'b10) begin
                chk("R9 ts_ready pending", 128'(ts_ready), 128'(1));
                send_ts(t);
                slave(a, t, r, 1'b0);
                chk("R6 status", 128'({done_flag, err_flag}),
                    128'({r == 2'b00, r != 2'b00}));
                pulse_clear();
            end else begin
                repeat (5) @(negedge clk);
                chk("R3 no write for flag", 128'({ts_ready, axi_awvalid, done_flag}), 128'(0));
            end
        end

        // R9: timestamp with nothing pending is ignored
        send_ts(80'hDEAD);
        repeat (4) @(negedge clk);
        chk("R9 stray ts ignored", 128'({axi_awvalid, ts_ready}), 128'(0));

        // R8: fill queue, refuse fifth, drain in order
        for (int k = 0; k < 4; k++) send_sof(2'b10, 32'h3000_0000 + 32'(k * 16));
        chk("R8 full", 128'(sof_ready), 128'(0));
        sof_valid = 1; sof_flag = 2'b10; sof_addr = 32'h4444_0000;
        @(negedge clk);
        sof_valid = 0;
        chk("R8 refused frame no strobe", 128'(mac_op_valid), 128'(0));
        for (int k = 0; k < 4; k++) begin
            send_ts(80'h55_0000_0000_0000_0000 + 80'(k));
            if (k == 0) chk("R8 ready after pop", 128'(sof_ready), 128'(1));
            slave(32'h3000_0000 + 32'(k * 16), 80'h55_0000_0000_0000_0000 + 80'(k), 2'b00, 1'b0);
        end
        chk("R8 drained", 128'({ts_ready, done_flag}), 128'({1'b0, 1'b1}));
        pulse_clear();

        // R7: set and clear in the same cycle, set wins
        send_sof(2'b10, 32'h5000_0000);
        send_ts(80'h1);
        slave(32'h5000_0000, 80'h1, 2'b00, 1'b1);
        chk("R7 set wins over clear", 128'(done_flag), 128'(1));
        pulse_clear();

        // R1: reset in mid-transfer returns to idle
        send_sof(2'b10, 32'h6000_0000);
        send_ts(80'h2);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset mid-write", 128'({axi_awvalid, ts_ready, sof_ready}), 128'({1'b0, 1'b0, 1'b1}));

        finish_run();
    end

endmodule